// File: doc/BRIEF.md
# Short-Vector Exception State Capture

This block records the state needed to resume a floating-point short-vector operation after one of its iterations raises a potential exception. On a capture strobe it takes the excepting instruction word, the vector length and stride codes, the index of the iteration that failed, the cause code, and an optional word for an instruction that already sits in the pipeline ahead of the trigger. In a single clock edge it stores all of this in capture registers. Before storing, it rewrites the destination and source register fields of the instruction word so that they name the registers of the failing iteration. Handler software can then replay that one iteration without knowing the vector state.

The control path is a three-state machine. `ST_IDLE` waits for work. The transition on `cap_strobe` loads the capture registers and enters `ST_BOUNCE`. In that state, for one cycle, the trigger instruction is rejected so that it can be reissued later. `ST_BOUNCE` always moves on to `ST_HELD`. In `ST_HELD` the captured state stays frozen until the exception-done input returns the machine to `ST_IDLE`.

Register numbers are handled per precision. A single-precision number is a 4-bit field holding the upper bits plus an extra bit holding the least significant bit. A double-precision number uses the 4-bit field alone, with the extra bit zero. For each iteration, the address advances within its bank: 8 registers per bank for single precision and 4 for double precision.

Top module: `vec_exc_capture`

## Requirements
- R1: After reset, every output is zero: `exc_active`, `trig_reject`, `exc_enable`, `second_valid`, `remain_code`, `cause_flags`, `cap_word` and `cap_second`.
- R2: A `cap_strobe` sampled while inactive sets `exc_active`, `exc_enable` and `trig_reject` from the next cycle on. `trig_reject` is high for exactly that one cycle.
- R3: Single precision (word bit 8 = 0) uses register number = {field, extra}. For the failing iteration i, the address becomes the bank bits {num[4:3]} followed by (num[2:0] + i*stride) mod 8. The stride is 2 for stride code 2'b11 and 1 for any other code.
- R4: Double precision (word bit 8 = 1) uses register number = field, with bank field[3:2] and index (field[1:0] + i*stride) mod 4. The extra bit is written as 0.
- R5: A source operand (Fn or Fm) whose register lies in bank 0 is not advanced. The destination is always advanced.
- R6: In the captured word, Fd sits at bits 15:12 with extra bit 22, Fn at bits 19:16 with extra bit 7, and Fm at bits 3:0 with extra bit 5. Every other bit of the exceptional word, including the condition field 31:28, is kept unchanged.
- R7: `remain_code` = (length code − failing index − 1) mod 8. The length code is the iteration count minus 1, so 3'b111 means no iterations remain.
- R8: Cause codes map to `cause_flags`: 2'b00 sets bit 0 (invalid), 2'b01 sets bit 1 (overflow), 2'b10 sets bit 2 (underflow), and 2'b11 sets none. At most one bit is set.
- R9: With `pre_valid` high, `cap_second` holds `pre_word` with bits 31:28 forced to 4'b1110 (always execute), and `second_valid` is 1. With `pre_valid` low, `second_valid` is 0.
- R10: While `exc_active` is high, `cap_strobe` is ignored. `cap_word`, `cap_second` and `cause_flags` stay unchanged, and no new `trig_reject` pulse appears.
- R11: `exc_done` in `ST_HELD` clears `exc_active` on the next cycle. `exc_done` while inactive has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_strobe | input | 1 | Capture request for a potential exception |
| exc_done | input | 1 | Exception processing finished |
| exc_word | input | 32 | Excepting instruction word |
| vec_len | input | LEN_W | Length code (iterations − 1) |
| vec_stride | input | 2 | Stride code (2'b11 = 2, else 1) |
| fail_iter | input | LEN_W | Index of the failing iteration, from 0 |
| cause_code | input | 2 | Exception cause code |
| pre_valid | input | 1 | A pretrigger instruction is present |
| pre_word | input | 32 | Pretrigger instruction word |
| trig_reject | output | 1 | Trigger rejected for reissue (one-cycle pulse) |
| exc_active | output | 1 | Exceptional state |
| exc_enable | output | 1 | Enable bit of the status register |
| second_valid | output | 1 | `cap_second` holds a valid word |
| remain_code | output | LEN_W | Remaining iterations − 1 |
| cause_flags | output | 3 | {underflow, overflow, invalid} |
| cap_word | output | 32 | Captured word with iteration addresses |
| cap_second | output | 32 | Captured pretrigger word |

## Verification
The bench builds the block with its default parameters: a 3-bit length code, 8-register single-precision banks and 4-register double-precision banks. With these values, a stride of 2 on an eight-long vector produces steps up to 14. Those steps wrap several times inside a bank, so both modulo paths are exercised, along with the all-ones remaining code at the last iteration. The table also places source operands in bank 0 in both precisions, and covers all four cause codes.

// File: rtl/vec_exc_pkg.sv
package vec_exc_pkg;

    localparam int WORD_W      = 32;
    localparam int REG_FIELD_W = 4;
    localparam int COND_W      = 4;
    localparam int COND_LSB    = 28;
    localparam int FN_LSB      = 16;
    localparam int FD_LSB      = 12;
    localparam int FM_LSB      = 0;
    localparam int DX_BIT      = 22;
    localparam int NX_BIT      = 7;
    localparam int MX_BIT      = 5;
    localparam int PREC_BIT    = 8;
    localparam int NUM_OPS     = 3;

    localparam logic [COND_W-1:0] COND_ALWAYS = 4'b1110;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BOUNCE = 2'd1,
        ST_HELD   = 2'd2
    } exc_state_e;

    typedef enum logic [1:0] {
        CAUSE_INV  = 2'd0,
        CAUSE_OVF  = 2'd1,
        CAUSE_UNF  = 2'd2,
        CAUSE_NONE = 2'd3
    } cause_e;

    typedef struct packed {
        logic unf;
        logic ovf;
        logic inv;
    } cause_flags_t;

endpackage

// File: rtl/vec_exc_regstep.sv
// Computes one operand's register address for a given vector iteration.
module vec_exc_regstep
    import vec_exc_pkg::*;
#(
    parameter int ITER_W        = 3,
    parameter int SGL_BANK_LOG2 = 3,
    parameter int DBL_BANK_LOG2 = 2,
    parameter bit IS_SOURCE     = 1'b0
) (
    input  logic [REG_FIELD_W-1:0] in_field,
    input  logic                   in_extra,
    input  logic                   is_dbl,
    input  logic [ITER_W-1:0]      iter,
    input  logic                   stride_two,
    output logic [REG_FIELD_W-1:0] out_field,
    output logic                   out_extra
);
    localparam int NUM_W  = REG_FIELD_W + 1;
    localparam int STEP_W = ITER_W + 1;

    logic [STEP_W-1:0]        step;
    logic [NUM_W-1:0]         sgl_num;
    logic [NUM_W-1:0]         sgl_next;
    logic [SGL_BANK_LOG2-1:0] sgl_idx;
    logic [DBL_BANK_LOG2-1:0] dbl_idx;
    logic [REG_FIELD_W-1:0]   dbl_next;
    logic                     hold;

    // iteration offset = index * stride
    assign step    = stride_two ? {iter, 1'b0} : {1'b0, iter};
    assign sgl_num = {in_field, in_extra};

    // modulo bank size falls out of the truncated index width
    assign sgl_idx  = sgl_num[SGL_BANK_LOG2-1:0] + SGL_BANK_LOG2'(step);
    assign sgl_next = {sgl_num[NUM_W-1:SGL_BANK_LOG2], sgl_idx};
    assign dbl_idx  = in_field[DBL_BANK_LOG2-1:0] + DBL_BANK_LOG2'(step);
    assign dbl_next = {in_field[REG_FIELD_W-1:DBL_BANK_LOG2], dbl_idx};

    generate
        if (IS_SOURCE) begin : g_src
            logic sgl_bank0;
            logic dbl_bank0;
            assign sgl_bank0 = (sgl_num[NUM_W-1:SGL_BANK_LOG2] == '0);
            assign dbl_bank0 = (in_field[REG_FIELD_W-1:DBL_BANK_LOG2] == '0);
            assign hold      = is_dbl ? dbl_bank0 : sgl_bank0;
        end else begin : g_dst
            assign hold = 1'b0;
        end
    endgenerate

    always_comb begin
        if (hold) begin
            out_field = in_field;
            out_extra = in_extra;
        end else if (is_dbl) begin
            out_field = dbl_next;
            out_extra = 1'b0;
        end else begin
            {out_field, out_extra} = sgl_next;
        end
    end

endmodule

// File: rtl/vec_exc_word_patch.sv
// Inserts iteration addresses into the word and forces the pretrigger condition.
module vec_exc_word_patch
    import vec_exc_pkg::*;
(
    input  logic [WORD_W-1:0]               word_in,
    input  logic [NUM_OPS-1:0][REG_FIELD_W-1:0] op_field,
    input  logic [NUM_OPS-1:0]              op_extra,
    input  logic [WORD_W-1:0]               pre_in,
    output logic [WORD_W-1:0]               word_out,
    output logic [WORD_W-1:0]               pre_out
);
    // operand order: 0 = destination, 1 = first source, 2 = second source
    always_comb begin
        word_out = word_in;
        word_out[FD_LSB +: REG_FIELD_W] = op_field[0];
        word_out[DX_BIT]                = op_extra[0];
        word_out[FN_LSB +: REG_FIELD_W] = op_field[1];
        word_out[NX_BIT]                = op_extra[1];
        word_out[FM_LSB +: REG_FIELD_W] = op_field[2];
        word_out[MX_BIT]                = op_extra[2];
    end

    always_comb begin
        pre_out = pre_in;
        pre_out[COND_LSB +: COND_W] = COND_ALWAYS;
    end

endmodule

// File: rtl/vec_exc_status.sv
// Remaining-iteration code and one-hot cause decode.
module vec_exc_status
    import vec_exc_pkg::*;
#(
    parameter int LEN_W = 3
) (
    input  logic [LEN_W-1:0] len_code,
    input  logic [LEN_W-1:0] iter,
    input  logic [1:0]       cause_code,
    output logic [LEN_W-1:0] remain,
    output cause_flags_t     flags
);
    assign remain = len_code - iter - LEN_W'(1);

    always_comb begin
        flags = '0;
        unique case (cause_e'(cause_code))
            CAUSE_INV:  flags.inv = 1'b1;
            CAUSE_OVF:  flags.ovf = 1'b1;
            CAUSE_UNF:  flags.unf = 1'b1;
            CAUSE_NONE: flags     = '0;
            default:    flags     = '0;
        endcase
    end

endmodule

// File: rtl/vec_exc_ctrl.sv
// Capture sequencing: idle, one-cycle trigger bounce, held exception.
module vec_exc_ctrl
    import vec_exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_strobe,
    input  logic exc_done,
    output logic load_en,
    output logic trig_reject,
    output logic exc_active
);
    exc_state_e state;
    exc_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (cap_strobe) state_nxt = ST_BOUNCE;
            ST_BOUNCE: state_nxt = ST_HELD;
            ST_HELD:   if (exc_done) state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en     = (state == ST_IDLE) && cap_strobe;
        trig_reject = (state == ST_BOUNCE);
        exc_active  = (state != ST_IDLE);
    end

endmodule

// File: rtl/vec_exc_capture.sv
module vec_exc_capture
    import vec_exc_pkg::*;
#(
    parameter int LEN_W         = 3,
    parameter int SGL_BANK_LOG2 = 3,
    parameter int DBL_BANK_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_strobe,
    input  logic              exc_done,
    input  logic [WORD_W-1:0] exc_word,
    input  logic [LEN_W-1:0]  vec_len,
    input  logic [1:0]        vec_stride,
    input  logic [LEN_W-1:0]  fail_iter,
    input  logic [1:0]        cause_code,
    input  logic              pre_valid,
    input  logic [WORD_W-1:0] pre_word,
    output logic              trig_reject,
    output logic              exc_active,
    output logic              exc_enable,
    output logic              second_valid,
    output logic [LEN_W-1:0]  remain_code,
    output logic [2:0]        cause_flags,
    output logic [WORD_W-1:0] cap_word,
    output logic [WORD_W-1:0] cap_second
);
    localparam logic [1:0] STRIDE2_CODE = 2'b11;

    logic                               load_en;
    logic                               is_dbl;
    logic                               stride_two;
    logic [NUM_OPS-1:0][REG_FIELD_W-1:0] in_field;
    logic [NUM_OPS-1:0]                 in_extra;
    logic [NUM_OPS-1:0][REG_FIELD_W-1:0] it_field;
    logic [NUM_OPS-1:0]                 it_extra;
    logic [WORD_W-1:0]                  patched;
    logic [WORD_W-1:0]                  pre_forced;
    logic [LEN_W-1:0]                   remain_nxt;
    cause_flags_t                       flags_nxt;

    assign is_dbl     = exc_word[PREC_BIT];
    assign stride_two = (vec_stride == STRIDE2_CODE);

    assign in_field[0] = exc_word[FD_LSB +: REG_FIELD_W];
    assign in_extra[0] = exc_word[DX_BIT];
    assign in_field[1] = exc_word[FN_LSB +: REG_FIELD_W];
    assign in_extra[1] = exc_word[NX_BIT];
    assign in_field[2] = exc_word[FM_LSB +: REG_FIELD_W];
    assign in_extra[2] = exc_word[MX_BIT];

    vec_exc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_strobe  (cap_strobe),
        .exc_done    (exc_done),
        .load_en     (load_en),
        .trig_reject (trig_reject),
        .exc_active  (exc_active)
    );

    for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
        vec_exc_regstep #(
            .ITER_W        (LEN_W),
            .SGL_BANK_LOG2 (SGL_BANK_LOG2),
            .DBL_BANK_LOG2 (DBL_BANK_LOG2),
            .IS_SOURCE     (k != 0)
        ) u_step (
            .in_field   (in_field[k]),
            .in_extra   (in_extra[k]),
            .is_dbl     (is_dbl),
            .iter       (fail_iter),
            .stride_two (stride_two),
            .out_field  (it_field[k]),
            .out_extra  (it_extra[k])
        );
    end

    vec_exc_word_patch u_patch (
        .word_in  (exc_word),
        .op_field (it_field),
        .op_extra (it_extra),
        .pre_in   (pre_word),
        .word_out (patched),
        .pre_out  (pre_forced)
    );

    vec_exc_status #(.LEN_W(LEN_W)) u_status (
        .len_code   (vec_len),
        .iter       (fail_iter),
        .cause_code (cause_code),
        .remain     (remain_nxt),
        .flags      (flags_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_enable   <= 1'b0;
            second_valid <= 1'b0;
            remain_code  <= '0;
            cause_flags  <= '0;
            cap_word     <= '0;
            cap_second   <= '0;
        end else if (load_en) begin
            exc_enable   <= 1'b1;
            second_valid <= pre_valid;
            remain_code  <= remain_nxt;
            cause_flags  <= flags_nxt;
            cap_word     <= patched;
            cap_second   <= pre_valid ? pre_forced : '0;
        end
    end

endmodule

// File: rtl/vec_exc_capture_chk.sv
module vec_exc_capture_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cap_strobe,
    input logic        exc_done,
    input logic        trig_reject,
    input logic        exc_active,
    input logic        second_valid,
    input logic [2:0]  cause_flags,
    input logic [31:0] cap_word,
    input logic [31:0] cap_second
);
    assert_reject_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_active && cap_strobe) |=> (trig_reject && exc_active));

    assert_reject_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        trig_reject |=> !trig_reject);

    assert_cause_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_flags));

    assert_second_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
        second_valid |-> (cap_second[31:28] == 4'b1110));

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_active |=> ($stable(cap_word) && $stable(cap_second) && $stable(cause_flags)));

    assert_done_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_active && !trig_reject && exc_done) |=> !exc_active);

    assert_idle_stays_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!exc_active && !cap_strobe) |=> !exc_active);

endmodule

bind vec_exc_capture vec_exc_capture_chk u_chk (.*);

// File: tb/vec_exc_capture_tb_top.sv
module vec_exc_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_strobe = 1'b0;
    logic        exc_done = 1'b0;
    logic [31:0] exc_word = '0;
    logic [2:0]  vec_len = '0;
    logic [1:0]  vec_stride = '0;
    logic [2:0]  fail_iter = '0;
    logic [1:0]  cause_code = '0;
    logic        pre_valid = 1'b0;
    logic [31:0] pre_word = '0;
    logic        trig_reject, exc_active, exc_enable, second_valid;
    logic [2:0]  remain_code, cause_flags;
    logic [31:0] cap_word, cap_second;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vec_exc_capture dut_i (.*);

    typedef struct packed {
        logic       dbl;
        logic [4:0] fd, fn, fm;
        logic [2:0] len;
        logic [1:0] strd;
        logic [2:0] iter;
        logic [1:0] cause;
        logic       pv;
        logic [4:0] efd, efn, efm;
        logic [2:0] erem;
        logic [2:0] ecause;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 5'd24, 5'd26, 5'd28, 3'd1, 2'b00, 3'd1, 2'd0, 1'b1, 5'd25, 5'd27, 5'd29, 3'b111, 3'b001},
        '{1'b0, 5'd8,  5'd12, 5'd16, 3'd3, 2'b11, 3'd2, 2'd1, 1'b0, 5'd12, 5'd8,  5'd20, 3'b000, 3'b010},
        '{1'b0, 5'd31, 5'd2,  5'd29, 3'd7, 2'b00, 3'd5, 2'd2, 1'b1, 5'd28, 5'd2,  5'd26, 3'b001, 3'b100},
        '{1'b1, 5'd8,  5'd14, 5'd10, 3'd3, 2'b00, 3'd2, 2'd2, 1'b0, 5'd10, 5'd12, 5'd8,  3'b000, 3'b100},
        '{1'b1, 5'd5,  5'd1,  5'd3,  3'd2, 2'b11, 3'd1, 2'd3, 1'b1, 5'd7,  5'd1,  5'd3,  3'b000, 3'b000},
        '{1'b0, 5'd17, 5'd9,  5'd0,  3'd0, 2'b00, 3'd0, 2'd0, 1'b0, 5'd17, 5'd9,  5'd0,  3'b111, 3'b001}
    };

    localparam logic [31:0] BASE_WORD = 32'hD0A0_0A50;

    function automatic logic [4:0] enc(input logic dbl, input logic [4:0] num);
        return dbl ? {num[3:0], 1'b0} : num;
    endfunction

    function automatic logic [31:0] mkword(input logic dbl, input logic [4:0] fd,
                                           input logic [4:0] fn, input logic [4:0] fm);
        logic [31:0] w;
        logic [4:0]  e;
        w = BASE_WORD;
        w[8] = dbl;
        e = enc(dbl, fd); w[15:12] = e[4:1]; w[22] = e[0];
        e = enc(dbl, fn); w[19:16] = e[4:1]; w[7]  = e[0];
        e = enc(dbl, fm); w[3:0]   = e[4:1]; w[5]  = e[0];
        return w;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v, input logic [31:0] pre);
        exc_word   = mkword(v.dbl, v.fd, v.fn, v.fm);
        vec_len    = v.len;
        vec_stride = v.strd;
        fail_iter  = v.iter;
        cause_code = v.cause;
        pre_valid  = v.pv;
        pre_word   = pre;
    endtask

    task automatic release_exc();
        @(negedge clk); exc_done = 1'b1;
        @(negedge clk); exc_done = 1'b0;
        chk("R11 active after done", {31'd0, exc_active}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 active", {31'd0, exc_active}, 32'd0);
        chk("R1 reject", {31'd0, trig_reject}, 32'd0);
        chk("R1 enable", {31'd0, exc_enable}, 32'd0);
        chk("R1 valid2", {31'd0, second_valid}, 32'd0);
        chk("R1 remain", {29'd0, remain_code}, 32'd0);
        chk("R1 cause", {29'd0, cause_flags}, 32'd0);
        chk("R1 word", cap_word, 32'd0);
        chk("R1 second", cap_second, 32'd0);
        rst_n = 1'b1;

        // R11: done while idle has no effect
        @(negedge clk); exc_done = 1'b1;
        @(negedge clk); exc_done = 1'b0;
        chk("R11 done idle active", {31'd0, exc_active}, 32'd0);
        chk("R11 done idle reject", {31'd0, trig_reject}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [31:0] pre;
            logic [31:0] exp_w;
            string atag;
            pre   = 32'h3123_4567 ^ (32'h0101_0101 * i);
            exp_w = mkword(VEC[i].dbl, VEC[i].efd, VEC[i].efn, VEC[i].efm);
            atag  = VEC[i].dbl ? "R4 R5 R6 word" : "R3 R5 R6 word";
            @(negedge clk);
            apply(VEC[i], pre);
            cap_strobe = 1'b1;
            @(negedge clk);
            cap_strobe = 1'b0;
            chk("R2 reject pulse", {31'd0, trig_reject}, 32'd1);
            chk("R2 active", {31'd0, exc_active}, 32'd1);
            chk("R2 enable", {31'd0, exc_enable}, 32'd1);
            chk(atag, cap_word, exp_w);
            chk("R7 remain", {29'd0, remain_code}, {29'd0, VEC[i].erem});
            chk("R8 cause", {29'd0, cause_flags}, {29'd0, VEC[i].ecause});
            chk("R9 valid2", {31'd0, second_valid}, {31'd0, VEC[i].pv});
            if (VEC[i].pv) chk("R9 second", cap_second, {4'b1110, pre[27:0]});
            @(negedge clk);
            chk("R2 reject single", {31'd0, trig_reject}, 32'd0);
            chk("R2 held active", {31'd0, exc_active}, 32'd1);
            if (i == 0) begin
                // R10: strobe while held is ignored
                apply(VEC[1], 32'h7777_7777);
                cap_strobe = 1'b1;
                @(negedge clk);
                cap_strobe = 1'b0;
                chk("R10 word kept", cap_word, exp_w);
                chk("R10 cause kept", {29'd0, cause_flags}, {29'd0, VEC[0].ecause});
                chk("R10 second kept", cap_second, {4'b1110, pre[27:0]});
                chk("R10 no reject", {31'd0, trig_reject}, 32'd0);
                @(negedge clk);
                chk("R10 no reject later", {31'd0, trig_reject}, 32'd0);
            end
            release_exc();
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule